// File: doc/BRIEF.md
# Instruction Start-Mark Predecoder with Mark Store

This block takes 16-byte fetch windows of a variable-length instruction stream and finds the byte where each instruction begins. The result is a 16-bit start mask with one bit per byte. The window and its mask go to the full decoders. A small length engine works out the length of each instruction from three things: its prefix bytes, a one- or two-byte opcode, and an optional addressing byte with the displacement it implies. An immediate-size table covers the rest.

The first time a line is seen, its window takes the slow path: a length stage, a chaining stage and a write-back stage. The write-back stage stores the marks in a per-line mark store, together with the number of bytes the last instruction spills into the next window. A later fetch of the same line finds valid marks and is sent on one cycle after acceptance, with no predecode latency. A cache refill or invalidation clears the stored marks of its line, so the next fetch of that line is predecoded again.

Windows are taken one at a time in fetch order. While a window is on the slow path, no new window is accepted, so the spill count always comes from the window just before. The output side uses a valid/ready handshake.

Top module: `boundary_marker`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and every line's marks are invalid, so the first fetch of any line takes the slow path.
- R2: Instruction length is computed as follows. The prefix bytes, the one-byte or 0x0F-escaped opcode, an addressing byte with its SIB and displacement, and the immediate are added together. Opcodes with an addressing byte are 0x00-0x3F with bit 2 clear, 0x80-0x8F, and every escaped opcode outside 0x80-0x8F. The immediate is one byte for 0x04-style opcodes (low three bits 100 within 0x00-0x3F), 0x70-0x7F, 0x80, 0x82, 0x83, 0xB0-0xB7 and 0xEB. It is four bytes for low three bits 101 within 0x00-0x3F, 0x81, 0xB8-0xBF, 0xE8, 0xE9 and escaped 0x80-0x8F. Bytes past the window end are read as 0x00.
- R3: Up to three leading bytes from the set 26, 2E, 36, 3E, 64, 65, 66, 67, F0, F2, F3 are taken as prefixes of the instruction. A fourth such byte in a row acts as a one-byte opcode, which ends the instruction at length 4.
- R4: Bit i of out_mask marks byte i (bits [8i+7:8i] of out_bytes) as an instruction start. When an instruction runs past byte 15, its remaining byte count is carried forward. In the next window those bytes get no mark, and the first start is at that carried offset.
- R5: A window whose line has no valid marks appears at the output 4 cycles after acceptance. Its marks and spill count are then written to that line's entry in the store.
- R6: A window whose line holds valid marks appears at the output 1 cycle after acceptance. Its out_mask is the stored mask, whatever the new bytes are.
- R7: Every window, whether predecoded or taken from the store, is delivered with its own bytes and line index unchanged.
- R8: inv_en clears the stored marks of inv_line, so the next fetch of that line takes the slow path again. An invalidation in the same cycle as a write-back to the same line takes precedence over it.
- R9: While out_valid is high and out_ready is low, the output holds its values. in_ready is low while a window is on the slow path or the output cannot be freed.
- R10: A window served from the store restores its stored spill count, and the next window is marked from that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch window offered |
| in_ready | output | 1 | Fetch window accepted this cycle |
| in_line | input | LW (4) | Cache line index of the window |
| in_bytes | input | 128 | Window bytes, byte i in bits [8i+7:8i] |
| inv_en | input | 1 | Clear the stored marks of inv_line |
| inv_line | input | LW (4) | Line whose marks are cleared |
| out_valid | output | 1 | Marked window available |
| out_ready | input | 1 | Decoder takes the window |
| out_line | output | LW (4) | Line index of the delivered window |
| out_bytes | output | 128 | Delivered window bytes |
| out_mask | output | 16 | Start mask, bit i for byte i |

## Verification
The checker watches the handshake on every cycle: the output holds still under backpressure, and no input is accepted while a slow-path window is in flight. It also follows the staging of a miss through its three stages, the one-cycle delivery of a hit, and the effect of invalidations and write-backs on each line's valid bit. The actual mask values cannot be checked by a property. These are the length rules, the prefix limit, the zero padding past the window end, and the spill count carried across windows and restored from the store. They are shown by the bench's directed windows and its random stream compared against a reference model.

// File: rtl/bmk_pkg.sv
package bmk_pkg;
  localparam int WIN    = 16;
  localparam int BW     = 8 * WIN;
  localparam int MAXLEN = 15;
  localparam int LENW   = $clog2(MAXLEN + 1);
  localparam int SPAN   = 8 * MAXLEN;
  localparam int NXW    = $clog2(2 * WIN);

  function automatic logic is_pfx(input logic [7:0] b);
    case (b)
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: is_pfx = 1'b1;
      default:                           is_pfx = 1'b0;
    endcase
  endfunction

  // Length of the instruction that starts at byte 0 of s.
  function automatic logic [LENW-1:0] ilen(input logic [SPAN-1:0] s);
    int p;
    int imm;
    logic [7:0] op;
    logic [7:0] m;
    logic has_m;
    p = 0;
    imm = 0;
    has_m = 1'b0;
    for (int k = 0; k < 3; k++)
      if (p == k && is_pfx(s[8*k +: 8])) p = k + 1;
    op = s[8*p +: 8];
    if (op == 8'h0F) begin
      op = s[8*(p+1) +: 8];
      p = p + 2;
      if (op[7:4] == 4'h8) imm = 4;
      else                 has_m = 1'b1;
    end else begin
      p = p + 1;
      if (op[7:6] == 2'b00) begin
        if (!op[2])                 has_m = 1'b1;
        else if (op[2:0] == 3'd4)   imm = 1;
        else if (op[2:0] == 3'd5)   imm = 4;
      end else if (op[7:4] == 4'h7) imm = 1;
      else if (op[7:4] == 4'h8) begin
        has_m = 1'b1;
        if (op == 8'h81)              imm = 4;
        else if (op[7:2] == 6'b100000) imm = 1;
      end else if (op[7:3] == 5'b10110) imm = 1;
      else if (op[7:3] == 5'b10111)     imm = 4;
      else if (op == 8'hE8 || op == 8'hE9) imm = 4;
      else if (op == 8'hEB)             imm = 1;
    end
    if (has_m) begin
      m = s[8*p +: 8];
      p = p + 1;
      if (m[7:6] != 2'b11 && m[2:0] == 3'd4) p = p + 1;
      if (m[7:6] == 2'b01)                       p = p + 1;
      else if (m[7:6] == 2'b10)                  p = p + 4;
      else if (m[7:6] == 2'b00 && m[2:0] == 3'd5) p = p + 4;
    end
    p = p + imm;
    return LENW'(p);
  endfunction
endpackage

// File: rtl/bmk_len_stage.sv
module bmk_len_stage
  import bmk_pkg::*;
(
  input  logic [BW-1:0]       bytes_i,
  output logic [WIN*LENW-1:0] lens_o
);
  localparam int PADW = BW + SPAN;
  logic [PADW-1:0] padded;
  assign padded = {{SPAN{1'b0}}, bytes_i};

  for (genvar i = 0; i < WIN; i++) begin : g_len
    assign lens_o[i*LENW +: LENW] = ilen(padded[8*i +: SPAN]);
  end
endmodule

// File: rtl/bmk_chain.sv
module bmk_chain
  import bmk_pkg::*;
(
  input  logic [WIN*LENW-1:0] lens_i,
  input  logic [LENW-1:0]     cin_i,
  output logic [WIN-1:0]      mask_o,
  output logic [LENW-1:0]     cout_o
);
  logic [NXW-1:0] nxt;

  always_comb begin
    nxt    = NXW'(cin_i);
    mask_o = '0;
    for (int i = 0; i < WIN; i++) begin
      if (nxt == NXW'(i)) begin
        mask_o[i] = 1'b1;
        nxt       = NXW'(i) + NXW'(lens_i[i*LENW +: LENW]);
      end
    end
    cout_o = LENW'(nxt - NXW'(WIN));
  end
endmodule

// File: rtl/bmk_mark_store.sv
module bmk_mark_store
  import bmk_pkg::*;
#(
  parameter int LINES = 16,
  localparam int LW   = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW-1:0]   rd_line,
  output logic            rd_valid,
  output logic [WIN-1:0]  rd_mask,
  output logic [LENW-1:0] rd_carry,
  input  logic            wr_en,
  input  logic [LW-1:0]   wr_line,
  input  logic [WIN-1:0]  wr_mask,
  input  logic [LENW-1:0] wr_carry,
  input  logic            inv_en,
  input  logic [LW-1:0]   inv_line,
  output logic [LINES-1:0] vld_o
);
  logic [LINES-1:0] vld_q, vld_d;
  logic [WIN-1:0]   mask_q  [LINES];
  logic [LENW-1:0]  carry_q [LINES];

  always_comb begin
    vld_d = vld_q;
    if (wr_en)  vld_d[wr_line]  = 1'b1;
    if (inv_en) vld_d[inv_line] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mask_q[wr_line]  <= wr_mask;
      carry_q[wr_line] <= wr_carry;
    end
  end

  assign rd_valid = vld_q[rd_line];
  assign rd_mask  = mask_q[rd_line];
  assign rd_carry = carry_q[rd_line];
  assign vld_o    = vld_q;
endmodule

// File: rtl/boundary_marker.sv
module boundary_marker
  import bmk_pkg::*;
#(
  parameter int LINES = 16,
  localparam int LW   = $clog2(LINES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [LW-1:0]  in_line,
  input  logic [BW-1:0]  in_bytes,
  input  logic           inv_en,
  input  logic [LW-1:0]  inv_line,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [LW-1:0]  out_line,
  output logic [BW-1:0]  out_bytes,
  output logic [WIN-1:0] out_mask
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  logic            hit, out_free, busy, in_fire, hit_fire, miss_fire;
  logic            wr_en, out_ld;
  logic [WIN-1:0]  rd_mask, ch_mask;
  logic [LENW-1:0] rd_carry, ch_cout;
  logic [LINES-1:0] vld;

  logic            s1_v, s2_v, s3_v, ov_q;
  logic            s1_v_d, s2_v_d, s3_v_d, ov_d;
  logic [BW-1:0]   s1_bytes, s2_bytes, s3_bytes, ob_q, ob_d;
  logic [LW-1:0]   s1_line, s2_line, s3_line, ol_q, ol_d;
  logic [WIN*LENW-1:0] s1_lens, s2_lens;
  logic [WIN-1:0]  s3_mask, om_q, om_d;
  logic [LENW-1:0] s3_cout, carry_q, carry_d;
  logic            carry_en;

  bmk_mark_store #(.LINES(LINES)) u_store (
    .clk(clk), .rst_n(rst_sn),
    .rd_line(in_line), .rd_valid(hit), .rd_mask(rd_mask), .rd_carry(rd_carry),
    .wr_en(wr_en), .wr_line(s3_line), .wr_mask(s3_mask), .wr_carry(s3_cout),
    .inv_en(inv_en), .inv_line(inv_line), .vld_o(vld)
  );

  bmk_len_stage u_len (.bytes_i(s1_bytes), .lens_o(s1_lens));

  bmk_chain u_chain (
    .lens_i(s2_lens), .cin_i(carry_q), .mask_o(ch_mask), .cout_o(ch_cout)
  );

  // next-state logic
  always_comb begin
    busy      = s1_v | s2_v | s3_v;
    out_free  = !ov_q | out_ready;
    in_ready  = !busy & out_free;
    in_fire   = in_valid & in_ready;
    hit_fire  = in_fire & hit;
    miss_fire = in_fire & !hit;
    s1_v_d    = miss_fire;
    s2_v_d    = s1_v;
    s3_v_d    = s2_v | (s3_v & !out_free);
    wr_en     = s3_v & out_free;
    out_ld    = out_free & (s3_v | hit_fire);
    ov_d      = out_free ? (s3_v | hit_fire) : 1'b1;
    if (s3_v) begin
      ob_d = s3_bytes; ol_d = s3_line; om_d = s3_mask;
    end else begin
      ob_d = in_bytes; ol_d = in_line; om_d = rd_mask;
    end
    carry_en = hit_fire | s2_v;
    carry_d  = hit_fire ? rd_carry : ch_cout;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      s1_v <= 1'b0; s2_v <= 1'b0; s3_v <= 1'b0; ov_q <= 1'b0;
      carry_q <= '0;
    end else begin
      s1_v <= s1_v_d; s2_v <= s2_v_d; s3_v <= s3_v_d; ov_q <= ov_d;
      if (carry_en) carry_q <= carry_d;
    end
  end

  // data registers, enabled by stage loads
  always_ff @(posedge clk) begin
    if (miss_fire) begin
      s1_bytes <= in_bytes; s1_line <= in_line;
    end
    if (s1_v) begin
      s2_bytes <= s1_bytes; s2_line <= s1_line; s2_lens <= s1_lens;
    end
    if (s2_v) begin
      s3_bytes <= s2_bytes; s3_line <= s2_line;
      s3_mask  <= ch_mask;  s3_cout <= ch_cout;
    end
    if (out_ld) begin
      ob_q <= ob_d; ol_q <= ol_d; om_q <= om_d;
    end
  end

  assign out_valid = ov_q;
  assign out_bytes = ob_q;
  assign out_line  = ol_q;
  assign out_mask  = om_q;
endmodule

// File: rtl/boundary_marker_chk.sv
module boundary_marker_chk
  import bmk_pkg::*;
#(
  parameter int LINES = 16,
  localparam int LW   = $clog2(LINES)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            hit,
  input logic            out_valid,
  input logic            out_ready,
  input logic [LW-1:0]   out_line,
  input logic [BW-1:0]   out_bytes,
  input logic [WIN-1:0]  out_mask,
  input logic            s1_v,
  input logic            s2_v,
  input logic            s3_v,
  input logic            inv_en,
  input logic [LW-1:0]   inv_line,
  input logic            wr_en,
  input logic [LW-1:0]   wr_line,
  input logic [LINES-1:0] vld
);
  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mask)
                                && $stable(out_bytes) && $stable(out_line));

  a_r9_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v || s2_v || s3_v) |-> !in_ready);

  a_r5_enter_slow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !hit |=> s1_v && !out_valid);

  a_r5_stage_two: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> s2_v);

  a_r5_stage_three: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v |=> s3_v);

  a_r6_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && hit |=> out_valid && !s1_v);

  a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !vld[$past(inv_line)]);

  a_r5_writeback_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !(inv_en && inv_line == wr_line) |=> vld[$past(wr_line)]);
endmodule

bind boundary_marker boundary_marker_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_sn), .in_valid(in_valid), .in_ready(in_ready),
  .hit(hit), .out_valid(out_valid), .out_ready(out_ready),
  .out_line(out_line), .out_bytes(out_bytes), .out_mask(out_mask),
  .s1_v(s1_v), .s2_v(s2_v), .s3_v(s3_v), .inv_en(inv_en),
  .inv_line(inv_line), .wr_en(wr_en), .wr_line(s3_line), .vld(vld)
);

// File: tb/boundary_marker_tb.sv
`timescale 1ns/1ps
module boundary_marker_tb;
  localparam int LINES = 16;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, inv_en, out_valid, out_ready;
  logic [LW-1:0] in_line, inv_line, out_line;
  logic [127:0] in_bytes, out_bytes;
  logic [15:0] out_mask;

  always #2.5 clk = ~clk;

  boundary_marker #(.LINES(LINES)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_line(in_line), .in_bytes(in_bytes), .inv_en(inv_en),
    .inv_line(inv_line), .out_valid(out_valid), .out_ready(out_ready),
    .out_line(out_line), .out_bytes(out_bytes), .out_mask(out_mask)
  );

  int nchk = 0;
  int nerr = 0;
  bit m_vld [LINES];
  logic [15:0] m_mask [LINES];
  int m_cout [LINES];
  int m_carry = 0;
  logic [15:0] last_mask;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [127:0] w, input int k);
    return (k < 16) ? w[8*k +: 8] : 8'h00;
  endfunction

  function automatic bit pfx(input logic [7:0] b);
    return b inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66,
                     8'h67, 8'hF0, 8'hF2, 8'hF3};
  endfunction

  function automatic int blen(input logic [127:0] w, input int s);
    int n = 0;
    int imm = 0;
    bit mr = 0;
    logic [7:0] op, m;
    while (n < 3 && pfx(byte_at(w, s + n))) n++;
    op = byte_at(w, s + n);
    n++;
    if (op == 8'h0F) begin
      op = byte_at(w, s + n);
      n++;
      if (op >= 8'h80 && op <= 8'h8F) imm = 4; else mr = 1;
    end else if (op < 8'h40) begin
      case (op % 8)
        0, 1, 2, 3: mr = 1;
        4: imm = 1;
        5: imm = 4;
        default: ;
      endcase
    end else begin
      case (op) inside
        [8'h70:8'h7F]: imm = 1;
        8'h81: begin mr = 1; imm = 4; end
        8'h80, 8'h82, 8'h83: begin mr = 1; imm = 1; end
        [8'h84:8'h8F]: mr = 1;
        [8'hB0:8'hB7]: imm = 1;
        [8'hB8:8'hBF]: imm = 4;
        8'hE8, 8'hE9: imm = 4;
        8'hEB: imm = 1;
        default: ;
      endcase
    end
    if (mr) begin
      m = byte_at(w, s + n);
      n++;
      if (m[7:6] != 2'd3 && m[2:0] == 3'd4) n++;
      case (m[7:6])
        2'd1: n += 1;
        2'd2: n += 4;
        2'd0: if (m[2:0] == 3'd5) n += 4;
        default: ;
      endcase
    end
    return n + imm;
  endfunction

  function automatic logic [15:0] model_mask(input logic [127:0] w,
                                             input int cin, output int cout);
    logic [15:0] mk = '0;
    int pos = cin;
    while (pos < 16) begin
      mk[pos] = 1'b1;
      pos = pos + blen(w, pos);
    end
    cout = pos - 16;
    return mk;
  endfunction

  task automatic fetch(input int line, input logic [127:0] w,
                       input int stall, input bit inv_mid);
    bit h;
    logic [15:0] em;
    int ec, lat, elat;
    h = m_vld[line];
    if (h) begin em = m_mask[line]; ec = m_cout[line]; elat = 1; end
    else begin em = model_mask(w, m_carry, ec); elat = 4; end
    out_ready = 1'b1;
    if (out_valid) @(negedge clk);
    out_ready = (stall == 0);
    in_valid = 1'b1; in_line = LW'(line); in_bytes = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      if (inv_mid && lat == 3) begin inv_en = 1'b1; inv_line = LW'(line); end
      @(negedge clk);
      inv_en = 1'b0;
      lat++;
    end
    chk(lat == elat, h ? "R6" : "R5", "latency", lat, elat);
    chk(out_mask == em, h ? "R6" : "R4", "mask", out_mask, em);
    chk(out_bytes == w, "R7", "bytes", out_bytes, w);
    chk(out_line == LW'(line), "R7", "line", out_line, line);
    last_mask = out_mask;
    m_carry = ec;
    if (!h) begin
      m_vld[line] = !inv_mid;
      m_mask[line] = em;
      m_cout[line] = ec;
    end
    if (stall > 0) begin
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk(out_valid && out_mask == em && out_bytes == w, "R9", "hold",
            out_mask, em);
        chk(!in_ready, "R9", "in_ready while blocked", in_ready, 0);
      end
      out_ready = 1'b1;
    end
  endtask

  task automatic do_inv(input int line);
    inv_en = 1'b1; inv_line = LW'(line);
    @(negedge clk);
    inv_en = 1'b0;
    m_vld[line] = 1'b0;
  endtask

  function automatic logic [127:0] fill(input logic [7:0] b);
    return {16{b}};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin : main
    logic [127:0] w;
    void'($urandom(32'd2024));
    for (int i = 0; i < LINES; i++) m_vld[i] = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_line = '0; in_bytes = '0;
    inv_en = 1'b0; inv_line = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R2 directed: 90 | 83 C0 05 | 0F 84 imm32 | 8B 44 24 08 | 90 90
    w = {8'h90, 8'h90, 8'h08, 8'h24, 8'h44, 8'h8B, 8'h00, 8'h00, 8'h00,
         8'h10, 8'h84, 8'h0F, 8'h05, 8'hC0, 8'h83, 8'h90};
    fetch(15, w, 0, 0);
    chk(last_mask == 16'hC413, "R2", "mixed lengths", last_mask, 16'hC413);

    // R3: four prefixes, then three prefixes + 05 imm32
    w = {8'h90, 8'h90, 8'h90, 8'h90, 8'h44, 8'h33, 8'h22, 8'h11, 8'h05,
         8'h66, 8'h2E, 8'hF3, 8'h66, 8'h66, 8'h66, 8'h66};
    fetch(14, w, 0, 0);
    chk(last_mask == 16'hF011, "R3", "prefix limit", last_mask, 16'hF011);

    // R4: B8 at byte 14 spills 3 bytes into the next window
    w = fill(8'h90); w[8*14 +: 16] = 16'h00B8;
    fetch(13, w, 0, 0);
    chk(last_mask == 16'h7FFF, "R4", "spill source", last_mask, 16'h7FFF);
    fetch(12, fill(8'h90), 0, 0);
    chk(last_mask == 16'hFFF8, "R4", "continuation unmarked", last_mask, 16'hFFF8);

    // R6: refetch line 15 with other bytes; stored mask comes back
    fetch(15, fill(8'h90), 0, 0);
    chk(last_mask == 16'hC413, "R6", "stored mask", last_mask, 16'hC413);

    // R10: hit on spilling line restores carry 3
    fetch(13, fill(8'h90), 0, 0);
    fetch(11, fill(8'h90), 0, 0);
    chk(last_mask == 16'hFFF8, "R10", "carry restored", last_mask, 16'hFFF8);

    // R8: invalidate line 15, refetch is predecoded again
    do_inv(15);
    fetch(15, fill(8'h90), 0, 0);
    chk(last_mask == 16'hFFFF, "R8", "recomputed", last_mask, 16'hFFFF);

    // R2: 0F at the last byte, bytes past the end read as 00 -> length 3
    w = fill(8'h90); w[8*15 +: 8] = 8'h0F;
    fetch(10, w, 0, 0);
    fetch(9, fill(8'h90), 0, 0);
    chk(last_mask == 16'hFFFC, "R2", "zero padding", last_mask, 16'hFFFC);

    // R8: invalidate wins over same-cycle write-back
    fetch(8, fill(8'h90), 0, 1);
    fetch(8, fill(8'hB0), 0, 0);   // must be a miss again (latency 4)

    // R9: backpressure on a hit and on a miss
    fetch(8, fill(8'h90), 3, 0);
    fetch(7, fill(8'h40), 2, 0);

    // random stream
    for (int it = 0; it < 400; it++) begin
      int ln;
      ln = $urandom % 8;
      if ($urandom % 8 == 0) do_inv($urandom % 8);
      w = {$urandom, $urandom, $urandom, $urandom};
      fetch(ln, w, ($urandom % 10 == 0) ? 1 + $urandom % 3 : 0, 0);
    end

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule